// File: doc/BRIEF.md
# Timer Compare Interrupt Unit

A shared free-running up-counter acts as the time base for a group of compare channels. The counter steps once per enabled tick, and a selectable divider derived from the input clock produces those ticks. Software can read the counter but can never load, clear or halt it. It wraps from all-ones back to zero.

Each channel holds a compare value written one byte at a time, plus three mode bits. A channel takes part in matching only when both its compare-enable and its match-enable bits are set. When the counter steps onto the channel's compare value, the channel sets a sticky flag. The flag becomes an interrupt request only when the channel's own interrupt enable is set. All requests are merged into one interrupt line, which is gated by a global enable. Writing the low compare byte suspends matching on that channel until the high byte arrives. This keeps a half-updated value from producing a false match.

Register map (byte-wide, address in `reg_addr`): 0 control (bit 0 global enable, bits 2:1 divider select), 1 flags, 2 counter low byte, 3 counter high byte. Each channel n owns three registers starting at 4+3n: mode (bit 0 compare-enable, bit 1 match-enable, bit 2 interrupt-enable), then compare low byte, then compare high byte.

Top module: `cmp_irq_unit`

## Requirements
- R1: After reset the counter reads 0. It advances by exactly one on every divider tick and wraps from 0xFFFF to 0x0000.
- R2: Control bits 2:1 select the tick rate. Code 0 gives one tick per clock, code 1 one per 2 clocks, code 2 one per 4 clocks and code 3 one per 12 clocks.
- R3: Writes to the counter registers (addresses 2 and 3) are ignored, and the counter keeps its course.
- R4: A channel's flag (bit n of register 1 and of `match_flag`) is set on the clock edge where the counter steps onto the channel's compare value {high byte, low byte}.
- R5: A channel matches only when mode bit 0 and mode bit 1 are both 1. Any other combination of those bits never sets the flag.
- R6: A flag is set regardless of the channel's interrupt enable. It stays set until software writes 0 to its bit in register 1, and bits written as 1 keep their value.
- R7: `irq` is 1 exactly when the global enable (control bit 0) is 1 and at least one channel has both its flag and its interrupt enable (mode bit 2) set.
- R8: A write to a channel's low compare byte blocks that channel from matching until its high compare byte is written. Once the high byte is written, matching resumes on the complete new value.
- R9: The control, mode and compare registers read back the values last written, and reset to 0.
- R10: A compare value just past the wrap point (0x0004) matches after the counter rolls over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| match_flag | output | 4 | Sticky per-channel match flags |
| irq | output | 1 | Combined, globally gated interrupt request |

## Verification
The divider is measured over a window of 96 clocks at each of the four settings. This length contains a whole number of ticks for every rate, so a single wrong ratio shows up as an exact count mismatch. Each channel is given a target some tens of counts ahead. The bench then checks the counter value in the first cycle the flag is seen, which separates a match on the step onto the value from one that is early or late. All eight mode-bit combinations are swept on one channel to expose any match allowed by fewer than both enable bits. The four combinations of global and channel interrupt enable are swept against a standing flag to expose wrong gating. Partial compare writes, flag clearing with mixed write-data bits, counter writes and a compare value past the wrap point cover the remaining corner cases.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

  localparam int BYTE_W      = 8;
  localparam int PRESC_W     = 2;
  localparam int PRESC_CNT_W = 4;
  localparam int MODE_W      = 3;

  localparam int REG_CTRL    = 0;
  localparam int REG_STAT    = 1;
  localparam int REG_CNTL    = 2;
  localparam int REG_CNTH    = 3;
  localparam int REG_CH_BASE = 4;
  localparam int REG_PER_CH  = 3;

  localparam int SUB_MODE  = 0;
  localparam int SUB_CMPLO = 1;
  localparam int SUB_CMPHI = 2;

  typedef enum logic [PRESC_W-1:0] {
    DIV_1  = 2'd0,
    DIV_2  = 2'd1,
    DIV_4  = 2'd2,
    DIV_12 = 2'd3
  } presc_e;

  // bit 0 = compare enable, bit 1 = match enable, bit 2 = interrupt enable
  typedef struct packed {
    logic ie;
    logic me;
    logic ce;
  } mode_t;

  function automatic int presc_divisor(input presc_e sel);
    case (sel)
      DIV_1:   return 1;
      DIV_2:   return 2;
      DIV_4:   return 4;
      default: return 12;
    endcase
  endfunction

  function automatic int reg_chan(input int addr);
    return (addr - REG_CH_BASE) / REG_PER_CH;
  endfunction

  function automatic int reg_sub(input int addr);
    return (addr - REG_CH_BASE) % REG_PER_CH;
  endfunction

  function automatic logic mode_armed(input mode_t m, input logic locked);
    return m.ce & m.me & ~locked;
  endfunction

endpackage

// File: rtl/cmp_prescaler.sv
module cmp_prescaler
  import cmp_irq_pkg::*;
#(
  parameter int CW = PRESC_CNT_W
) (
  input  logic   clk,
  input  logic   rst_n,
  input  presc_e sel,
  output logic   tick
);

  logic [CW-1:0] phase_q;
  logic [CW-1:0] limit;

  always_comb begin
    limit = CW'(presc_divisor(sel) - 1);
    tick  = (phase_q >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/cmp_timebase.sv
module cmp_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next
);

  assign cnt_next = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_next;
    end
  end

endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
  import cmp_irq_pkg::*;
#(
  parameter int BW    = BYTE_W,
  parameter int CNT_W = 2 * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mode,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [BW-1:0]    wdata,
  input  logic             clr_flag,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_next,
  output mode_t            mode_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             lock_q,
  output logic             flag_q,
  output logic             match_evt,
  output logic             req
);

  logic hit;
  logic armed;

  always_comb begin
    hit       = (cnt_next == cmp_q);
    armed     = mode_armed(mode_q, lock_q);
    match_evt = tick & armed & hit;
    req       = flag_q & mode_q.ie;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_mode) begin
      mode_q <= mode_t'(wdata[MODE_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (wr_lo) begin
        cmp_q[BW-1:0] <= wdata;
        lock_q        <= 1'b1;
      end
      if (wr_hi) begin
        cmp_q[CNT_W-1:BW] <= wdata;
        lock_q            <= 1'b0;
      end
    end
  end

  // a new match wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (match_evt) begin
      flag_q <= 1'b1;
    end else if (clr_flag) begin
      flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/cmp_irq_unit.sv
module cmp_irq_unit
  import cmp_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] match_flag,
  output logic              irq
);

  localparam int CNT_W   = 2 * BYTE_W;
  localparam int REG_END = REG_CH_BASE + REG_PER_CH * NUM_CH;

  // named internal events, brought out for the checker
  logic              gie_q;
  presc_e            presc_q;
  logic              tick_w;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_next;
  logic              ctrl_wr;
  logic              stat_wr;
  logic [NUM_CH-1:0] clr_vec;
  logic [NUM_CH-1:0] match_evt_vec;
  logic [NUM_CH-1:0] lock_vec;
  logic [NUM_CH-1:0] req_vec;
  logic [NUM_CH-1:0] ce_vec;
  logic [NUM_CH-1:0] me_vec;
  logic [NUM_CH-1:0] ie_vec;
  mode_t             mode_arr [NUM_CH];
  logic [CNT_W-1:0]  cmp_arr  [NUM_CH];

  assign ctrl_wr = reg_wr && (int'(reg_addr) == REG_CTRL);
  assign stat_wr = reg_wr && (int'(reg_addr) == REG_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q   <= 1'b0;
      presc_q <= DIV_1;
    end else if (ctrl_wr) begin
      gie_q   <= reg_wdata[0];
      presc_q <= presc_e'(reg_wdata[PRESC_W:1]);
    end
  end

  cmp_prescaler u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (presc_q),
    .tick  (tick_w)
  );

  cmp_timebase #(.CNT_W(CNT_W)) u_tbase (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_w),
    .cnt_q    (cnt_q),
    .cnt_next (cnt_next)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int BASE = REG_CH_BASE + REG_PER_CH * i;
    logic wr_mode;
    logic wr_lo;
    logic wr_hi;

    assign wr_mode    = reg_wr && (int'(reg_addr) == BASE + SUB_MODE);
    assign wr_lo      = reg_wr && (int'(reg_addr) == BASE + SUB_CMPLO);
    assign wr_hi      = reg_wr && (int'(reg_addr) == BASE + SUB_CMPHI);
    assign clr_vec[i] = stat_wr && !reg_wdata[i];

    cmp_channel #(.BW(BYTE_W), .CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_mode   (wr_mode),
      .wr_lo     (wr_lo),
      .wr_hi     (wr_hi),
      .wdata     (reg_wdata),
      .clr_flag  (clr_vec[i]),
      .tick      (tick_w),
      .cnt_next  (cnt_next),
      .mode_q    (mode_arr[i]),
      .cmp_q     (cmp_arr[i]),
      .lock_q    (lock_vec[i]),
      .flag_q    (match_flag[i]),
      .match_evt (match_evt_vec[i]),
      .req       (req_vec[i])
    );

    assign ce_vec[i] = mode_arr[i].ce;
    assign me_vec[i] = mode_arr[i].me;
    assign ie_vec[i] = mode_arr[i].ie;
  end

  assign irq = gie_q & (|req_vec);

  always_comb begin
    int a;
    int ch;
    int sub;
    a         = int'(reg_addr);
    ch        = reg_chan(a);
    sub       = reg_sub(a);
    reg_rdata = '0;
    if (a == REG_CTRL) begin
      reg_rdata = {{(BYTE_W - 1 - PRESC_W){1'b0}}, presc_q, gie_q};
    end else if (a == REG_STAT) begin
      reg_rdata = {{(BYTE_W - NUM_CH){1'b0}}, match_flag};
    end else if (a == REG_CNTL) begin
      reg_rdata = cnt_q[BYTE_W-1:0];
    end else if (a == REG_CNTH) begin
      reg_rdata = cnt_q[CNT_W-1:BYTE_W];
    end else if (a >= REG_CH_BASE && a < REG_END) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch == i) begin
          if (sub == SUB_MODE) begin
            reg_rdata = {{(BYTE_W - MODE_W){1'b0}}, mode_arr[i]};
          end else if (sub == SUB_CMPLO) begin
            reg_rdata = cmp_arr[i][BYTE_W-1:0];
          end else begin
            reg_rdata = cmp_arr[i][CNT_W-1:BYTE_W];
          end
        end
      end
    end
  end

endmodule

// File: rtl/cmp_irq_chk.sv
module cmp_irq_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [CNT_W-1:0]  count,
  input logic [1:0]        presc_sel,
  input logic              gie,
  input logic [NUM_CH-1:0] ce_vec,
  input logic [NUM_CH-1:0] me_vec,
  input logic [NUM_CH-1:0] ie_vec,
  input logic [NUM_CH-1:0] lock_vec,
  input logic [NUM_CH-1:0] match_evt,
  input logic [NUM_CH-1:0] clr_vec,
  input logic [NUM_CH-1:0] match_flag,
  input logic              irq
);

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count == CNT_W'($past(count) + 1'b1)));

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  assert_div1_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_sel == 2'd0) |-> tick);

  assert_irq_global_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie);

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(match_flag & ie_vec)));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_match_modes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt[i] |-> (ce_vec[i] && me_vec[i]));

    assert_match_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt[i] |-> !lock_vec[i]);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (match_flag[i] && !clr_vec[i]) |=> match_flag[i]);

    assert_flag_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_flag[i]) |-> $past(match_evt[i]));
  end

endmodule

bind cmp_irq_unit cmp_irq_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick_w),
  .count      (cnt_q),
  .presc_sel  (presc_q),
  .gie        (gie_q),
  .ce_vec     (ce_vec),
  .me_vec     (me_vec),
  .ie_vec     (ie_vec),
  .lock_vec   (lock_vec),
  .match_evt  (match_evt_vec),
  .clr_vec    (clr_vec),
  .match_flag (match_flag),
  .irq        (irq)
);

// File: tb/cmp_irq_unit_tb.sv
module cmp_irq_unit_tb_top;

  logic       clk;
  logic       rst_n;
  logic [3:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [3:0] match_flag;
  logic       irq;

  int  checks;
  int  errors;
  bit  done;

  cmp_irq_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .match_flag (match_flag),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic read_count(output logic [15:0] v);
    logic [7:0] h;
    logic [7:0] l;
    rd(4'd3, h);
    rd(4'd2, l);
    v = {h, l};
  endtask

  task automatic wait_window();
    logic [7:0] l;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      rd(4'd2, l);
      if (l >= 8'h08 && l < 8'h40) break;
    end
  endtask

  task automatic wait_flag(input int ch, input int maxc, output bit found,
                           output logic [15:0] got);
    found = 1'b0;
    got   = '0;
    for (int k = 0; k < maxc; k++) begin
      @(negedge clk);
      if (match_flag[ch]) begin
        read_count(got);
        found = 1'b1;
        break;
      end
    end
  endtask

  task automatic program_ch(input int ch, input logic [15:0] t, input logic [7:0] m);
    wr(4'(4 + 3 * ch + 1), t[7:0]);
    wr(4'(4 + 3 * ch + 2), t[15:8]);
    wr(4'(4 + 3 * ch), m);
  endtask

  initial begin
    logic [15:0] v;
    logic [15:0] t;
    logic [15:0] got;
    logic [7:0]  a;
    logic [7:0]  b;
    bit          found;

    checks    = 0;
    errors    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // reset state: R1, R9
    read_count(v);
    chk(v == 16'd0, "R1 counter at reset", int'(v), 0);
    chk(match_flag == 4'd0, "R6 flags at reset", int'(match_flag), 0);
    chk(irq == 1'b0, "R7 irq at reset", int'(irq), 0);
    rd(4'd0, a);
    chk(a == 8'd0, "R9 control at reset", int'(a), 0);
    rd(4'd8, a);
    chk(a == 8'd0, "R9 compare at reset", int'(a), 0);

    // R3: counter writes ignored, count keeps stepping once per clock
    @(negedge clk);
    read_count(v);
    wr(4'd2, 8'hAA);
    wr(4'd3, 8'h55);
    read_count(t);
    chk(t == v + 16'd4, "R3 counter write ignored", int'(t), int'(v + 16'd4));

    // R2: divider sweep over a 96-clock window
    for (int s = 0; s < 4; s++) begin
      int div;
      div = (s == 3) ? 12 : (1 << s);
      wr(4'd0, 8'(s << 1));
      repeat (24) @(negedge clk);
      rd(4'd2, a);
      repeat (96) @(negedge clk);
      rd(4'd2, b);
      chk(8'(b - a) == 8'(96 / div), "R2 divider ratio", int'(8'(b - a)), 96 / div);
    end
    wr(4'd0, 8'h00);
    rd(4'd0, a);
    chk(a == 8'h00, "R9 control readback", int'(a), 0);

    // R4: each channel flags on the step onto its target
    for (int ch = 0; ch < 4; ch++) begin
      wr(4'd1, 8'h00);
      wait_window();
      read_count(v);
      t = v + 16'd40;
      program_ch(ch, t, 8'h03);
      wait_flag(ch, 100, found, got);
      chk(found && got == t, "R4 flag on compare step", int'(got), int'(t));
      chk(match_flag == 4'(1 << ch), "R6 flag set without interrupt enable",
          int'(match_flag), 1 << ch);
      chk(irq == 1'b0, "R7 irq off with enables clear", int'(irq), 0);
      rd(4'(4 + 3 * ch + 1), a);
      rd(4'(4 + 3 * ch + 2), b);
      chk({b, a} == t, "R9 compare readback", int'({b, a}), int'(t));
      rd(4'(4 + 3 * ch), a);
      chk(a == 8'h03, "R9 mode readback", int'(a), 3);
    end
    wr(4'd1, 8'h00);
    chk(match_flag == 4'd0, "R6 clear by writing zero", int'(match_flag), 0);

    // R5: all mode combinations on channel 1
    for (int m = 0; m < 8; m++) begin
      bit expf;
      expf = (m & 3) == 3;
      wr(4'd1, 8'h00);
      wait_window();
      read_count(v);
      program_ch(1, v + 16'd30, 8'(m));
      repeat (50) @(negedge clk);
      chk(match_flag[1] == expf, "R5 mode gating", int'(match_flag[1]), int'(expf));
    end

    // R6: stickiness and selective clear
    repeat (300) @(negedge clk);
    chk(match_flag[1] == 1'b1, "R6 flag holds", int'(match_flag[1]), 1);
    wr(4'd1, 8'h00);
    wait_window();
    read_count(v);
    program_ch(0, v + 16'd40, 8'h03);
    program_ch(1, v + 16'd45, 8'h07);
    repeat (60) @(negedge clk);
    chk(match_flag == 4'b0011, "R6 two flags set", int'(match_flag), 3);
    wr(4'd1, 8'hFD);
    chk(match_flag == 4'b0001, "R6 selective clear", int'(match_flag), 1);
    wr(4'd1, 8'hFF);
    chk(match_flag == 4'b0001, "R6 ones leave flags", int'(match_flag), 1);

    // R7: enable combinations against a standing flag on channel 0
    wr(4'd10, 8'h04);
    for (int c = 0; c < 4; c++) begin
      logic g;
      logic ie;
      g  = c[0];
      ie = c[1];
      wr(4'd4, {5'd0, ie, 2'b00});
      wr(4'd0, {7'd0, g});
      chk(irq == (g & ie), "R7 irq gating", int'(irq), int'(g & ie));
      chk(match_flag[0] == 1'b1, "R6 flag kept over mode write", int'(match_flag[0]), 1);
    end
    wr(4'd0, 8'h00);
    wr(4'd10, 8'h00);
    wr(4'd1, 8'h00);

    // R8: low-byte write blocks matching until high byte arrives
    wait_window();
    read_count(v);
    t = v + 16'hA0;
    program_ch(2, t, 8'h03);
    t = v + 16'd40;
    wr(4'd11, t[7:0]);
    repeat (60) @(negedge clk);
    chk(match_flag[2] == 1'b0, "R8 blocked after low write", int'(match_flag[2]), 0);
    read_count(v);
    t = v + 16'd40;
    wr(4'd11, t[7:0]);
    wr(4'd12, t[15:8]);
    wait_flag(2, 100, found, got);
    chk(found && got == t, "R8 armed after high write", int'(got), int'(t));

    // R10: match past the wrap point on channel 3
    wr(4'd1, 8'h00);
    program_ch(3, 16'h0004, 8'h03);
    read_count(v);
    wait_flag(3, 70000, found, got);
    chk(found && got == 16'h0004, "R10 match after wrap", int'(got), 4);
    chk(v > 16'h0004, "R1 counter wrapped", int'(v), 5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule